// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock timing for an I2C controller. A first stage divides the peripheral clock by one plus a small divide field to make an internal tick. A second stage counts internal ticks across one SCL period. The period length is a fixed base of 20 ticks, plus eight ticks for each step of a coarse step field, plus a compensation count. The compensation count covers the line's fall time, rise time and internal delay, rounded up to whole ticks.

Software works out the divider and compensation values and writes them in. The block drives SCL low for the low phase and releases it for the high phase. It gives the bit engine a one-cycle strobe before each falling point and before each rising point. If a target holds the line low while it is released, the high phase is stretched. New divider values are only picked up at a period boundary, so no SCL period is ever cut short. Dropping the run input parks the line released.

Top module: `scl_timing_gen`

## Requirements
- R1: While active, the internal tick fires once every 1 + CDF peripheral clocks, and the phase counter moves by at most one step per tick.
- R2: One SCL period lasts P = 20 + 8·SCGD + COMP internal ticks. Without stretching, successive `fall_stb` pulses are (1 + CDF)·P clocks apart.
- R3: `div_cfg` holds CDF in bits [CDF_W-1:0] and SCGD, 6 bits, in bits [CDF_W+5:CDF_W]. CDF_W is a parameter of 2 or 3.
- R4: Each period starts with `scl_out` = 0 for ceil(P/2) ticks, followed by `scl_out` = 1 for the remaining floor(P/2) ticks.
- R5: In the high phase, while `scl_in` reads 0, the phase count holds and `scl_out` stays 1, so the period grows by the length of the hold.
- R6: A new `div_cfg` or `comp_ticks` value is taken on only in the cycle that ends a period, or while idle. It never takes effect mid-period.
- R7: While `run` is 0, `scl_out` is 1, both strobes are 0 and both counters are cleared. When `run` rises, a period starts at once in its low phase.
- R8: `fall_stb` pulses for one clock in the last clock of each period; the next clock shows `scl_out` = 0. `rise_stb` pulses in the last clock of the low phase; the next clock shows `scl_out` = 1. The two never coincide.
- R9: While `rst` is 1, the outputs are the same as in the idle state, whatever `run` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables SCL generation |
| div_cfg | input | CDF_W+6 | Packed divider value: CDF low, SCGD above |
| comp_ticks | input | COMP_W | Rise/fall compensation in internal ticks |
| scl_in | input | 1 | Sensed SCL line level |
| scl_out | output | 1 | 0 = drive SCL low, 1 = release |
| fall_stb | output | 1 | Clock before SCL is pulled low |
| rise_stb | output | 1 | Clock before SCL is released |

## Verification
The bound checker checks on every cycle:
- the idle state;
- that the two strobes never coincide;
- that a strobe is followed by the matching line level;
- that a stretched high phase cannot end;
- that a period starts low;
- that the latched configuration does not change inside a period.

The exact period and low-phase lengths cannot be seen by those properties, nor can the tick spacing for each CDF, the field packing, or the boundary at which a mid-period write takes effect. Those come from the bench's reference model and its period measurements across several divider settings.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int SCGD_W      = 6;
    localparam int CDF_MAX_W   = 3;
    localparam int COMP_MAX_W  = 8;
    localparam int BASE_TICKS  = 20;
    localparam int STEP_SHIFT  = 3;
    localparam int PH_W        = 10;

    typedef struct packed {
        logic [CDF_MAX_W-1:0]  cdf;
        logic [SCGD_W-1:0]     scgd;
        logic [COMP_MAX_W-1:0] comp;
    } scl_cfg_t;

    function automatic logic [PH_W-1:0] period_ticks(scl_cfg_t c);
        return PH_W'(BASE_TICKS) + (PH_W'(c.scgd) << STEP_SHIFT) + PH_W'(c.comp);
    endfunction

    function automatic logic [PH_W-1:0] low_ticks(logic [PH_W-1:0] p);
        return (p + PH_W'(1)) >> 1;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CDF_MAX_W-1:0] div_m1,
    output logic                 tick
);
    logic [CDF_MAX_W-1:0] cnt;

    assign tick = en && (cnt == div_m1);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
    import scl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic [PH_W-1:0] period,
    input  logic [PH_W-1:0] low_len,
    input  logic            line_in,
    output logic            drive_low,
    output logic            boundary,
    output logic            rise
);
    logic [PH_W-1:0] ph;
    logic            in_high;
    logic            stall;
    logic            adv;
    logic            last;

    assign in_high   = ph >= low_len;
    assign stall     = in_high && !line_in;
    assign adv       = en && tick && !stall;
    assign last      = ph == (period - 1'b1);
    assign boundary  = adv && last;
    assign rise      = en && tick && (ph == (low_len - 1'b1));
    assign drive_low = en && !in_high;

    always_ff @(posedge clk) begin
        if (rst || !en)
            ph <= '0;
        else if (adv)
            ph <= last ? '0 : ph + 1'b1;
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_pkg::*;
#(
    parameter int CDF_W  = 2,
    parameter int COMP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic [CDF_W+SCGD_W-1:0]  div_cfg,
    input  logic [COMP_W-1:0]        comp_ticks,
    input  logic                     scl_in,
    output logic                     scl_out,
    output logic                     fall_stb,
    output logic                     rise_stb
);
    localparam int CFG_W = CDF_W + SCGD_W;

    scl_cfg_t        cfg_next;
    scl_cfg_t        cfg_q;
    logic            active;
    logic            tick;
    logic            drive_low;
    logic [PH_W-1:0] period;
    logic [PH_W-1:0] low_len;

    generate
        if (CDF_W == CDF_MAX_W) begin : g_wide_cdf
            assign cfg_next.cdf = div_cfg[CDF_W-1:0];
        end else begin : g_narrow_cdf
            assign cfg_next.cdf = CDF_MAX_W'(div_cfg[CDF_W-1:0]);
        end
    endgenerate

    assign cfg_next.scgd = div_cfg[CFG_W-1:CDF_W];
    assign cfg_next.comp = COMP_MAX_W'(comp_ticks);

    assign active  = run && !rst;
    assign period  = period_ticks(cfg_q);
    assign low_len = low_ticks(period);

    always_ff @(posedge clk) begin
        if (rst || !run || fall_stb)
            cfg_q <= cfg_next;
    end

    scl_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (active),
        .div_m1 (cfg_q.cdf),
        .tick   (tick)
    );

    scl_phase_ctr u_ph (
        .clk       (clk),
        .rst       (rst),
        .en        (active),
        .tick      (tick),
        .period    (period),
        .low_len   (low_len),
        .line_in   (scl_in),
        .drive_low (drive_low),
        .boundary  (fall_stb),
        .rise      (rise_stb)
    );

    assign scl_out = !drive_low;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
    import scl_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     run,
    input logic     scl_in,
    input logic     scl_out,
    input logic     fall_stb,
    input logic     rise_stb,
    input scl_cfg_t cfg_q
);
    // R7
    a_r7_idle_released: assert property (@(posedge clk) disable iff (rst)
        !run |-> (scl_out && !fall_stb && !rise_stb));

    // R7 / R4
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !scl_out);

    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(fall_stb && rise_stb));

    a_r8_rise_releases: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> scl_out);

    a_r8_fall_pulls_low: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> (!run || !scl_out));

    a_r5_stretch_holds: assert property (@(posedge clk) disable iff (rst)
        (run && scl_out && !scl_in) |=> scl_out);

    a_r6_cfg_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst) && !$past(fall_stb)) |-> $stable(cfg_q));
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .scl_in   (scl_in),
    .scl_out  (scl_out),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .cfg_q    (cfg_q)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    localparam int CW = 2;
    localparam int RW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          hold = 1'b0;
    logic [CW+5:0] cfg = '0;
    logic [RW-1:0] comp = '0;
    logic          scl_out, fall_stb, rise_stb;
    wire           scl_in;

    assign scl_in = scl_out & ~hold;

    scl_timing_gen #(.CDF_W(CW), .COMP_W(RW)) dut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .div_cfg    (cfg),
        .comp_ticks (comp),
        .scl_in     (scl_in),
        .scl_out    (scl_out),
        .fall_stb   (fall_stb),
        .rise_stb   (rise_stb)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string req    = "R9";

    // reference model state
    int m_pre = 0, m_ph = 0, m_cdf = 0, m_scgd = 0, m_comp = 0;

    function automatic int per();
        return 20 + 8 * m_scgd + m_comp;
    endfunction
    function automatic int lowl();
        return (per() + 1) / 2;
    endfunction
    function automatic bit m_act();
        return run && !rst;
    endfunction

    task automatic take_cfg();
        m_cdf  = int'(cfg[CW-1:0]);
        m_scgd = int'(cfg[CW+5:CW]);
        m_comp = int'(comp);
    endtask

    always @(posedge clk) begin
        bit tk, st;
        if (rst || !run) begin
            m_pre = 0;
            m_ph  = 0;
            take_cfg();
        end else begin
            tk = (m_pre == m_cdf);
            st = (m_ph >= lowl()) && hold;
            m_pre = tk ? 0 : m_pre + 1;
            if (tk && !st) begin
                if (m_ph == per() - 1) begin
                    m_ph = 0;
                    take_cfg();
                end else begin
                    m_ph = m_ph + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        bit tk, st, e_scl, e_fall, e_rise;
        e_scl  = !(m_act() && m_ph < lowl());
        tk     = m_act() && (m_pre == m_cdf);
        st     = (m_ph >= lowl()) && hold;
        e_fall = tk && !st && (m_ph == per() - 1);
        e_rise = tk && (m_ph == lowl() - 1);
        checks++;
        if ({scl_out, fall_stb, rise_stb} !== {e_scl, e_fall, e_rise}) begin
            fails++;
            $display("FAIL %s cycle compare: scl/fall/rise act=%b%b%b exp=%b%b%b",
                     req, scl_out, fall_stb, rise_stb, e_scl, e_fall, e_rise);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // clocks between two successive fall strobes
    task automatic measure_period(int exp, string tag);
        int n;
        do @(negedge clk); while (!fall_stb);
        n = 0;
        do begin @(negedge clk); n++; end while (!fall_stb);
        checks++;
        if (n != exp) begin
            fails++;
            $display("FAIL %s period clocks act=%0d exp=%0d", tag, n, exp);
        end
        step(1);
    endtask

    // clocks with scl_out low inside one period
    task automatic measure_low(int exp, string tag);
        int n;
        do @(negedge clk); while (!fall_stb);
        n = 0;
        do begin @(negedge clk); if (!scl_out) n++; end while (!fall_stb);
        checks++;
        if (n != exp) begin
            fails++;
            $display("FAIL %s low clocks act=%0d exp=%0d", tag, n, exp);
        end
        step(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        // R9: reset with run high must look idle
        run = 1'b1;
        step(4);
        run = 1'b0;
        rst = 1'b0;
        req = "R7";
        step(5);

        // R1: fastest setting, CDF=0 SCGD=0 COMP=0
        req = "R1";
        cfg = {6'd0, 2'd0}; comp = 4'd0; run = 1'b1;
        step(70);
        req = "R2";
        measure_period(20, "R2");

        // R3: field packing, CDF=2 SCGD=1 -> P=28, 3 clocks per tick
        req = "R3";
        run = 1'b0; step(1);
        cfg = {6'd1, 2'd2}; comp = 4'd0; run = 1'b1;
        measure_period(84, "R3");

        // R4: odd period, CDF=1 COMP=1 -> P=21, low 11 ticks = 22 clocks
        req = "R4";
        run = 1'b0; step(1);
        cfg = {6'd0, 2'd1}; comp = 4'd1; run = 1'b1;
        measure_low(22, "R4");
        measure_period(42, "R4");

        // R6: change config mid-period
        req = "R6";
        run = 1'b0; step(1);
        cfg = {6'd0, 2'd0}; comp = 4'd0; run = 1'b1;
        step(7);
        cfg = {6'd2, 2'd1}; comp = 4'd3;
        step(13);
        measure_period(2 * 39, "R6");

        // R5: stretch during high phase
        req = "R5";
        run = 1'b0; step(1);
        cfg = {6'd0, 2'd0}; comp = 4'd0; run = 1'b1;
        step(2);
        while (!scl_out) step(1);
        hold = 1'b1;
        step(25);
        checks++;
        if (scl_out !== 1'b1) begin
            fails++;
            $display("FAIL R5 scl during stretch act=%b exp=1", scl_out);
        end
        hold = 1'b0;
        step(60);

        // R7: run dropped mid-period then restored
        req = "R7";
        step(5);
        run = 1'b0;
        step(4);
        run = 1'b1;
        step(50);

        // R9: reset mid-run
        req = "R9";
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(40);

        // R2: largest setting, CDF=3 SCGD=63 COMP=15 -> P=539
        req = "R2";
        run = 1'b0; step(1);
        cfg = {6'd63, 2'd3}; comp = 4'd15; run = 1'b1;
        measure_period(4 * 539, "R2");

        req = "R8";
        step(30);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog expired act=running exp=finished", req);
            finish_run();
        end
    end
endmodule